// File: doc/BRIEF.md
# LED Command Register Slave

This block is a memory-mapped AXI4-Lite slave that controls a red and a green indicator LED through address-decoded commands, not through a data register. Inside a 16-byte window, four word offsets each carry one fixed action: light the red LED, darken the red LED, light the green LED, or darken the green LED. Software sets or clears one LED with a single store to the matching offset. The value stored does not matter, and no setup write is needed first.

The write address and write data channels are accepted independently and in either order. The command runs once both have been taken, and the OKAY response is then held until the master accepts it. The block accepts reads only so that the bus cannot stall: every read returns zero data with an error response. Both LED outputs are driven at all times, and reset turns them off.

Top module: `axil_led_cmd`

## Requirements
- R1: While `rst` is high (synchronous, active high), both LEDs are turned off and all handshake state is cleared. After the first clock edge with reset asserted, `s_bvalid`=0, `s_rvalid`=0, and `s_awready`, `s_wready` and `s_arready` are 1.
- R2: A write to byte offset 0x0 turns the red LED on.
- R3: A write to byte offset 0x4 turns the red LED off.
- R4: A write to byte offset 0x8 turns the green LED on.
- R5: A write to byte offset 0xC turns the green LED off.
- R6: The value of `s_wdata` and of `s_wstrb` has no effect. Only the offset selects the action.
- R7: The address and the data may arrive in the same cycle, address first, or data first, with idle cycles between them. Neither the LEDs nor `s_bvalid` change until both have been accepted.
- R8: The command's effect and `s_bvalid`=1 with `s_bresp`=00 (OKAY) appear together, one edge after the last of the two handshakes. `s_bvalid` stays high until a cycle with `s_bready`=1. While it is high, `s_awready` and `s_wready` are 0.
- R9: A write to any other offset in the window (0x1–0x3, 0x5–0x7, 0x9–0xB, 0xD–0xF) changes neither LED and still completes with OKAY.
- R10: A read is accepted when `s_arready`=1. It returns `s_rvalid`=1 with `s_rdata`=0 and `s_rresp`=10 (SLVERR), and `s_rvalid` is held until `s_rready`=1.
- R11: A write to a red offset never changes the green LED, and a write to a green offset never changes the red LED.
- R12: An LED changes only in the cycle in which a write response is first presented. Reads and partly received writes leave both LEDs as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data (ignored) |
| s_wstrb | input | DATA_W/8 | Write byte strobes (ignored) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address (ignored) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data, always zero |
| s_rresp | output | 2 | Read response code |
| led_red | output | 1 | Red LED drive, 1 = lit |
| led_green | output | 1 | Green LED drive, 1 = lit |

## Verification
Each of the four command offsets is written with the address and data together, with the address leading, and with the data leading. The split orders show whether the action fires early on a half-received write. The data patterns include all-zero data with all strobes off and all-ones data with all strobes on, which separates decoding by address from any dependence on the payload. Unaligned offsets are written while both LEDs are lit, which shows whether the decoder ignores the low address bits. A response held back for several cycles, a read between writes, and a reset in the middle of operation show whether the response hold, the error read path and the reset each leave the LED state as the requirements say.

// File: rtl/axil_led_cmd_pkg.sv
package axil_led_cmd_pkg;

    // Byte window covered by the slave and the word size used for decode
    localparam int unsigned OFF_W      = 4;
    localparam int unsigned WORD_LSB_W = 2;

    typedef logic [1:0] axi_resp_t;
    localparam axi_resp_t RESP_OKAY   = 2'b00;
    localparam axi_resp_t RESP_SLVERR = 2'b10;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_RED_SET,
        CMD_RED_CLR,
        CMD_GRN_SET,
        CMD_GRN_CLR
    } led_cmd_e;

    typedef struct packed {
        logic red;
        logic green;
    } led_state_t;

    // Map a window offset onto its command; unaligned offsets do nothing
    function automatic led_cmd_e offset_to_cmd(input logic [OFF_W-1:0] off);
        led_cmd_e c;
        if (off[WORD_LSB_W-1:0] != '0) begin
            c = CMD_NOP;
        end else begin
            unique case (off[OFF_W-1:WORD_LSB_W])
                2'd0:    c = CMD_RED_SET;
                2'd1:    c = CMD_RED_CLR;
                2'd2:    c = CMD_GRN_SET;
                default: c = CMD_GRN_CLR;
            endcase
        end
        return c;
    endfunction

    // Apply one command to the LED pair
    function automatic led_state_t apply_cmd(input led_state_t s, input led_cmd_e c);
        led_state_t n;
        n = s;
        unique case (c)
            CMD_RED_SET: n.red   = 1'b1;
            CMD_RED_CLR: n.red   = 1'b0;
            CMD_GRN_SET: n.green = 1'b1;
            CMD_GRN_CLR: n.green = 1'b0;
            default:     n       = s;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/axil_led_cmd_wr_chan.sv
module axil_led_cmd_wr_chan
    import axil_led_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output axi_resp_t         bresp,
    output logic              fire,
    output logic [ADDR_W-1:0] fire_addr
);

    logic              aw_full_q;
    logic              w_full_q;
    logic              bvalid_q;
    logic [ADDR_W-1:0] addr_q;
    logic              aw_hs;
    logic              w_hs;

    assign awready = !aw_full_q && !bvalid_q;
    assign wready  = !w_full_q && !bvalid_q;
    assign aw_hs   = awvalid && awready;
    assign w_hs    = wvalid && wready;

    // Both halves present (held or arriving now): command executes this edge
    assign fire      = (aw_full_q || aw_hs) && (w_full_q || w_hs);
    assign fire_addr = aw_full_q ? addr_q : awaddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_full_q <= 1'b0;
            w_full_q  <= 1'b0;
            bvalid_q  <= 1'b0;
            addr_q    <= '0;
        end else begin
            if (fire) begin
                aw_full_q <= 1'b0;
                w_full_q  <= 1'b0;
                bvalid_q  <= 1'b1;
            end else begin
                if (aw_hs) begin
                    aw_full_q <= 1'b1;
                    addr_q    <= awaddr;
                end
                if (w_hs) begin
                    w_full_q <= 1'b1;
                end
                if (bvalid_q && bready) begin
                    bvalid_q <= 1'b0;
                end
            end
        end
    end

    assign bvalid = bvalid_q;
    assign bresp  = RESP_OKAY;

endmodule

// File: rtl/axil_led_cmd_decode.sv
module axil_led_cmd_decode
    import axil_led_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output led_cmd_e          cmd
);

    logic in_window;

    generate
        if (ADDR_W > OFF_W) begin : g_wide
            assign in_window = ~|addr[ADDR_W-1:OFF_W];
        end else begin : g_exact
            assign in_window = 1'b1;
        end
    endgenerate

    assign cmd       = in_window ? offset_to_cmd(addr[OFF_W-1:0]) : CMD_NOP;
    assign cmd_valid = valid && (cmd != CMD_NOP);

endmodule

// File: rtl/axil_led_cmd_led_bank.sv
module axil_led_cmd_led_bank
    import axil_led_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  led_cmd_e   cmd,
    output led_state_t leds
);

    led_state_t leds_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            leds_q <= '0;
        end else if (cmd_valid) begin
            leds_q <= apply_cmd(leds_q, cmd);
        end
    end

    assign leds = leds_q;

endmodule

// File: rtl/axil_led_cmd_rd_chan.sv
module axil_led_cmd_rd_chan
    import axil_led_cmd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arvalid,
    output logic              arready,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output axi_resp_t         rresp
);

    logic      rvalid_q;
    axi_resp_t rresp_q;

    assign arready = !rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rresp_q  <= RESP_OKAY;
        end else if (arvalid && arready) begin
            rvalid_q <= 1'b1;
            rresp_q  <= RESP_SLVERR;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign rvalid = rvalid_q;
    assign rresp  = rresp_q;
    assign rdata  = '0;

endmodule

// File: rtl/axil_led_cmd.sv
module axil_led_cmd
    import axil_led_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_wvalid,
    output logic                s_wready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [1:0]          s_bresp,
    input  logic                s_arvalid,
    output logic                s_arready,
    input  logic [ADDR_W-1:0]   s_araddr,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                led_red,
    output logic                led_green
);

    logic              fire;
    logic [ADDR_W-1:0] fire_addr;
    logic              cmd_valid;
    led_cmd_e          cmd;
    led_state_t        leds;

    // Payload and read address carry no meaning for this slave
    logic unused_payload;
    assign unused_payload = ^{s_wdata, s_wstrb, s_araddr};

    axil_led_cmd_wr_chan #(.ADDR_W(ADDR_W)) i_wr (
        .clk       (clk),
        .rst       (rst),
        .awvalid   (s_awvalid),
        .awready   (s_awready),
        .awaddr    (s_awaddr),
        .wvalid    (s_wvalid),
        .wready    (s_wready),
        .bvalid    (s_bvalid),
        .bready    (s_bready),
        .bresp     (s_bresp),
        .fire      (fire),
        .fire_addr (fire_addr)
    );

    axil_led_cmd_decode #(.ADDR_W(ADDR_W)) i_dec (
        .valid     (fire),
        .addr      (fire_addr),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    axil_led_cmd_led_bank i_bank (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .leds      (leds)
    );

    axil_led_cmd_rd_chan #(.DATA_W(DATA_W)) i_rd (
        .clk     (clk),
        .rst     (rst),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rdata   (s_rdata),
        .rresp   (s_rresp)
    );

    assign led_red   = leds.red;
    assign led_green = leds.green;

endmodule

// File: rtl/axil_led_cmd_chk.sv
module axil_led_cmd_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              s_awready,
    input logic              s_wready,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [1:0]        s_bresp,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [DATA_W-1:0] s_rdata,
    input logic [1:0]        s_rresp,
    input logic              led_red,
    input logic              led_green
);

    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (!led_red && !led_green && !s_bvalid && !s_rvalid));

    assert_bvalid_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> s_bvalid);

    assert_bresp_okay_R8: assert property (@(posedge clk) disable iff (rst)
        s_bvalid |-> (s_bresp == 2'b00));

    assert_no_accept_pending_R8: assert property (@(posedge clk) disable iff (rst)
        s_bvalid |-> (!s_awready && !s_wready));

    assert_read_error_R10: assert property (@(posedge clk) disable iff (rst)
        s_rvalid |-> (s_rresp == 2'b10 && s_rdata == '0));

    assert_rvalid_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> s_rvalid);

    assert_one_led_moves_R11: assert property (@(posedge clk) disable iff (rst)
        !((led_red != $past(led_red)) && (led_green != $past(led_green))));

    assert_change_with_resp_R12: assert property (@(posedge clk) disable iff (rst)
        ((led_red != $past(led_red)) || (led_green != $past(led_green)))
            |-> (s_bvalid && !$past(s_bvalid)));

endmodule

bind axil_led_cmd axil_led_cmd_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .s_awready (s_awready),
    .s_wready  (s_wready),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_bresp   (s_bresp),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .led_red   (led_red),
    .led_green (led_green)
);

// File: tb/test_axil_led_cmd.sv
`timescale 1ns/1ps
module test_axil_led_cmd;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              s_awvalid = 1'b0;
    logic              s_awready;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic              s_wvalid = 1'b0;
    logic              s_wready;
    logic [DATA_W-1:0] s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_bvalid;
    logic              s_bready = 1'b0;
    logic [1:0]        s_bresp;
    logic              s_arvalid = 1'b0;
    logic              s_arready;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic              s_rvalid;
    logic              s_rready = 1'b0;
    logic [DATA_W-1:0] s_rdata;
    logic [1:0]        s_rresp;
    logic              led_red;
    logic              led_green;

    int n_cmp = 0;
    int n_bad = 0;
    logic exp_red = 1'b0;
    logic exp_grn = 1'b0;

    always #10 clk = ~clk;

    axil_led_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_axil_led_cmd (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_leds(input string req);
        check(req, "led_red", {31'd0, led_red}, {31'd0, exp_red});
        check(req, "led_green", {31'd0, led_green}, {31'd0, exp_grn});
    endtask

    // Model: offset 0x0 red on, 0x4 red off, 0x8 green on, 0xC green off
    task automatic model_apply(input logic [3:0] a);
        if (a[1:0] == 2'b00) begin
            case (a[3:2])
                2'd0: exp_red = 1'b1;
                2'd1: exp_red = 1'b0;
                2'd2: exp_grn = 1'b1;
                default: exp_grn = 1'b0;
            endcase
        end
    endtask

    // order: 0 together, 1 address first, 2 data first
    task automatic axi_write(input logic [3:0] a, input logic [31:0] d,
                             input logic [3:0] strb, input int order,
                             input int bwait, input string req);
        @(negedge clk);
        s_awaddr = a;
        s_wdata  = d;
        s_wstrb  = strb;
        if (order == 0) begin
            s_awvalid = 1'b1;
            s_wvalid  = 1'b1;
            @(negedge clk);
            s_awvalid = 1'b0;
            s_wvalid  = 1'b0;
        end else begin
            if (order == 1) s_awvalid = 1'b1; else s_wvalid = 1'b1;
            @(negedge clk);
            s_awvalid = 1'b0;
            s_wvalid  = 1'b0;
            s_awaddr  = 4'h5;
            check("R7", "bvalid after half", {31'd0, s_bvalid}, 32'd0);
            check_leds("R12");
            @(negedge clk);
            check("R7", "bvalid idle gap", {31'd0, s_bvalid}, 32'd0);
            check_leds("R7");
            s_awaddr = (order == 1) ? 4'h5 : a;
            if (order == 1) s_wvalid = 1'b1; else s_awvalid = 1'b1;
            @(negedge clk);
            s_awvalid = 1'b0;
            s_wvalid  = 1'b0;
        end
        model_apply(a);
        check("R8", "bvalid", {31'd0, s_bvalid}, 32'd1);
        check("R8", "bresp", {30'd0, s_bresp}, 32'd0);
        check_leds(req);
        for (int i = 0; i < bwait; i++) begin
            @(negedge clk);
            check("R8", "bvalid held", {31'd0, s_bvalid}, 32'd1);
            check("R8", "awready while pending", {31'd0, s_awready}, 32'd0);
            check("R8", "wready while pending", {31'd0, s_wready}, 32'd0);
        end
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
        check("R8", "bvalid cleared", {31'd0, s_bvalid}, 32'd0);
        check_leds(req);
    endtask

    task automatic t_reset();
        check_leds("R1");
        check("R1", "bvalid", {31'd0, s_bvalid}, 32'd0);
        check("R1", "rvalid", {31'd0, s_rvalid}, 32'd0);
        check("R1", "awready", {31'd0, s_awready}, 32'd1);
        check("R1", "wready", {31'd0, s_wready}, 32'd1);
        check("R1", "arready", {31'd0, s_arready}, 32'd1);
    endtask

    task automatic t_red();
        axi_write(4'h0, 32'h0000_0001, 4'hF, 0, 0, "R2");
        check("R11", "green untouched", {31'd0, led_green}, 32'd0);
        axi_write(4'h4, 32'hFFFF_FFFF, 4'hF, 1, 0, "R3");
    endtask

    task automatic t_green();
        axi_write(4'h0, 32'h0, 4'hF, 0, 0, "R2");
        axi_write(4'h8, 32'h0, 4'hF, 2, 0, "R4");
        check("R11", "red kept on", {31'd0, led_red}, 32'd1);
        axi_write(4'hC, 32'h1234_5678, 4'h3, 1, 0, "R5");
        check("R11", "red still on", {31'd0, led_red}, 32'd1);
        axi_write(4'h4, 32'h0, 4'hF, 2, 0, "R3");
        check("R11", "green stays off", {31'd0, led_green}, 32'd0);
    endtask

    task automatic t_payload_ignored();
        axi_write(4'h0, 32'h0, 4'h0, 0, 0, "R6");
        axi_write(4'h8, 32'h0, 4'h0, 1, 0, "R6");
        axi_write(4'h4, 32'hFFFF_FFFF, 4'hF, 2, 0, "R6");
        axi_write(4'hC, 32'hFFFF_FFFF, 4'h0, 0, 0, "R6");
    endtask

    task automatic t_unaligned();
        axi_write(4'h0, 32'h0, 4'hF, 0, 0, "R2");
        axi_write(4'h8, 32'h0, 4'hF, 0, 0, "R4");
        axi_write(4'h5, 32'hFFFF_FFFF, 4'hF, 0, 0, "R9");
        axi_write(4'hD, 32'h0, 4'hF, 1, 0, "R9");
        axi_write(4'h6, 32'h0, 4'hF, 2, 0, "R9");
        axi_write(4'hF, 32'h0, 4'hF, 0, 0, "R9");
        axi_write(4'h1, 32'h0, 4'hF, 0, 0, "R9");
        check("R9", "red still on", {31'd0, led_red}, 32'd1);
        check("R9", "green still on", {31'd0, led_green}, 32'd1);
    endtask

    task automatic t_backpressure();
        axi_write(4'h4, 32'h0, 4'hF, 0, 3, "R3");
        axi_write(4'h0, 32'h0, 4'hF, 1, 4, "R2");
    endtask

    task automatic t_read();
        @(negedge clk);
        s_araddr  = 4'h0;
        s_arvalid = 1'b1;
        @(negedge clk);
        s_arvalid = 1'b0;
        check("R10", "rvalid", {31'd0, s_rvalid}, 32'd1);
        check("R10", "rdata", s_rdata, 32'd0);
        check("R10", "rresp", {30'd0, s_rresp}, 32'd2);
        check("R10", "arready busy", {31'd0, s_arready}, 32'd0);
        @(negedge clk);
        check("R10", "rvalid held", {31'd0, s_rvalid}, 32'd1);
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
        check("R10", "rvalid cleared", {31'd0, s_rvalid}, 32'd0);
        check_leds("R12");
    endtask

    task automatic t_reset_mid();
        axi_write(4'h8, 32'h0, 4'hF, 0, 0, "R4");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_red = 1'b0;
        exp_grn = 1'b0;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_red();
        t_green();
        t_payload_ignored();
        t_unaligned();
        t_backpressure();
        t_read();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule